// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block takes an asynchronous serial line that idles high and turns it into received characters. It runs on the system clock and uses a one-cycle strobe, `rt_tick`, that the surrounding logic asserts sixteen times per bit period. The line is first passed through a short synchronizer. A falling edge is accepted as the start of a character only if three early samples in the start bit confirm it. Each data bit and the stop bit are then decided by a majority of three samples taken around the middle of the bit.

When the stop bit has been decided, the received field is placed in a holding register. The flags are updated at the same moment: full, noise, framing error and parity error. The low eight bits of the field and the ninth bit come out on separate ports. The host takes the word with a one-cycle `host_read` strobe, and that strobe clears the full flag and all error flags. If a new character completes while the previous one is still unread, the holding register keeps the old word and raises the overrun flag.

Word length, parity enable, parity type and receiver enable are static configuration inputs. The three format inputs are captured when a start bit is accepted and hold for that whole character.

Top module: `rxo_receiver`

## Requirements
- R1: After reset, `rx_data`, `rx_bit8`, `rx_full`, `rx_overrun`, `rx_noise`, `rx_frame_err` and `rx_parity_err` are all 0.
- R2: A start is armed only after the line has been seen high on a tick. The first tick that sees the line low is RT1. The line is sampled at RT3, RT5 and RT7. If two or more of these samples are 1, the start is dropped, `rx_noise` is set on that tick and `rx_full` is not touched. If exactly one of them is 1, the character is received and carries the noise flag.
- R3: Each data bit and the stop bit take the majority value of the samples at RT8, RT9 and RT10 of their bit period. If those three samples disagree, the noise flag is set for that character.
- R4: A character is one low start bit, then the field bits least significant first, then one stop bit. The field is 8 bits when `cfg_nine` is 0 and 9 bits when `cfg_nine` is 1. Field bits 7..0 appear on `rx_data`. Field bit 8 appears on `rx_bit8`, which is 0 for 8-bit characters.
- R5: When `cfg_par_en` is 1, the most significant field bit is the parity bit, and it is still delivered as part of the field. With `cfg_par_odd` = 0 the total count of ones in the field must be even; with `cfg_par_odd` = 1 it must be odd. A mismatch sets `rx_parity_err`.
- R6: A stop bit decided as 0 sets `rx_frame_err`, and the word is still delivered. After such a character, a new start is accepted only once the line has been seen high again.
- R7: `rx_full` and the three error flags are updated on the tick of the stop bit's RT10 sample. A `host_read` strobe clears `rx_full`, `rx_overrun`, `rx_noise`, `rx_frame_err` and `rx_parity_err` on the next edge.
- R8: Suppose a character completes while `rx_full` is 1 and `host_read` is low in that cycle. Then `rx_overrun` is set, the unread word and its flags stay unchanged, and the new character is discarded.
- R9: If `host_read` is high in the same cycle that a character completes, the new word is loaded, `rx_full` stays 1 and `rx_overrun` stays 0.
- R10: While `rx_en` is 0 the receiver stays idle and disarmed. A character sent during that time produces no word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| cfg_nine | input | 1 | 1 selects a 9-bit field, 0 an 8-bit field |
| cfg_par_en | input | 1 | 1 treats the field MSB as parity and checks it |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| host_read | input | 1 | One-cycle strobe that takes the held word |
| rx_data | output | 8 | Field bits 7..0 of the held word |
| rx_bit8 | output | 1 | Field bit 8 of the held word |
| rx_full | output | 1 | A word is waiting to be read |
| rx_overrun | output | 1 | A character was lost while the word was unread |
| rx_noise | output | 1 | Sample disagreement or a rejected start |
| rx_frame_err | output | 1 | Stop bit was received low |
| rx_parity_err | output | 1 | Parity check failed |

## Verification
A host read and the completion of a character can land on the same clock edge. The order in which that edge resolves them decides whether the new word is taken or an overrun is recorded. To provoke it, the bench leaves one word unread and then sends a second character. It raises `host_read` exactly in the cycle whose edge carries the RT10 tick of that second character's stop bit. The pass condition is that the second word is visible, `rx_full` is still set and `rx_overrun` is clear. The same sequence without the read must instead keep the first word and raise `rx_overrun`.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    localparam int FIELD_W = 9;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               noise;
        logic               frame_err;
        logic               parity_err;
    } rx_word_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/rxo_line_sync.sv
module rxo_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/rxo_frame_fsm.sv
module rxo_frame_fsm
    import rxo_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int FLD_W   = rxo_pkg::FIELD_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line,
    input  logic     en,
    input  logic     cfg_nine,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    output logic     done,
    output logic     reject,
    output rx_word_t word
);

    localparam int CW = $clog2(OSR + 1);
    localparam int BW = $clog2(FLD_W);
    localparam logic [CW-1:0] CHK_A = CW'(OSR / 2 - 5);
    localparam logic [CW-1:0] CHK_B = CW'(OSR / 2 - 3);
    localparam logic [CW-1:0] CHK_C = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] MID_A = CW'(OSR / 2);
    localparam logic [CW-1:0] MID_B = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] MID_C = CW'(OSR / 2 + 2);
    localparam logic [CW-1:0] BIT_END = CW'(OSR);
    localparam logic [BW-1:0] LAST9 = BW'(FLD_W - 1);
    localparam logic [BW-1:0] LAST8 = BW'(FLD_W - 2);

    typedef struct packed {
        rx_state_e          state;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      idx;
        logic [BW-1:0]      last;
        logic [1:0]         samp;
        logic [FLD_W-1:0]   field;
        logic               noise;
        logic               armed;
        logic               par_en;
        logic               par_odd;
    } fsm_t;

    fsm_t          st_d, st_q;
    logic [CW-1:0] nxt;
    logic          vbit;
    logic          vsplit;

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        reject = 1'b0;
        nxt    = st_q.cnt + 1'b1;
        vbit   = vote3(line, st_q.samp[1], st_q.samp[0]);
        vsplit = split3(line, st_q.samp[1], st_q.samp[0]);

        word.field      = st_q.field;
        word.noise      = st_q.noise | vsplit;
        word.frame_err  = ~vbit;
        word.parity_err = st_q.par_en & ((^st_q.field) != st_q.par_odd);

        if (!en) begin
            st_d.state = RX_IDLE;
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (tick) begin
            unique case (st_q.state)
                RX_IDLE: begin
                    if (line) begin
                        st_d.armed = 1'b1;
                    end else if (st_q.armed) begin
                        st_d.state   = RX_START;
                        st_d.cnt     = CW'(1);
                        st_d.idx     = '0;
                        st_d.samp    = '0;
                        st_d.field   = '0;
                        st_d.noise   = 1'b0;
                        st_d.armed   = 1'b0;
                        st_d.last    = cfg_nine ? LAST9 : LAST8;
                        st_d.par_en  = cfg_par_en;
                        st_d.par_odd = cfg_par_odd;
                    end
                end
                RX_START: begin
                    st_d.cnt = nxt;
                    if (nxt == CHK_A) begin
                        st_d.samp[0] = line;
                    end else if (nxt == CHK_B) begin
                        st_d.samp[1] = line;
                    end else if (nxt == CHK_C) begin
                        if (vbit) begin
                            reject     = 1'b1;
                            st_d.state = RX_IDLE;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.noise = vsplit;
                        end
                    end else if (nxt == BIT_END) begin
                        st_d.state = RX_DATA;
                        st_d.cnt   = '0;
                    end
                end
                RX_DATA: begin
                    st_d.cnt = nxt;
                    if (nxt == MID_A) begin
                        st_d.samp[0] = line;
                    end else if (nxt == MID_B) begin
                        st_d.samp[1] = line;
                    end else if (nxt == MID_C) begin
                        st_d.field[st_q.idx] = vbit;
                        st_d.noise           = st_q.noise | vsplit;
                    end else if (nxt == BIT_END) begin
                        st_d.cnt = '0;
                        if (st_q.idx == st_q.last) st_d.state = RX_STOP;
                        else                       st_d.idx   = st_q.idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    st_d.cnt = nxt;
                    if (nxt == MID_A) begin
                        st_d.samp[0] = line;
                    end else if (nxt == MID_B) begin
                        st_d.samp[1] = line;
                    end else if (nxt == MID_C) begin
                        done       = 1'b1;
                        st_d.state = RX_IDLE;
                        st_d.cnt   = '0;
                        st_d.armed = vbit;
                    end
                end
                default: st_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!done && !reject && st_q.state == RX_IDLE));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.state == RX_IDLE && !done));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= BIT_END);

    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != RX_IDLE) |-> (st_q.idx <= st_q.last));

endmodule

// File: rtl/rxo_result_reg.sv
module rxo_result_reg
    import rxo_pkg::*;
#(
    parameter int FLD_W = rxo_pkg::FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             reject,
    input  rx_word_t         word,
    input  logic             host_read,
    output logic [FLD_W-1:0] data,
    output logic             full,
    output logic             overrun,
    output logic             noise,
    output logic             frame_err,
    output logic             parity_err
);

    typedef struct packed {
        logic [FLD_W-1:0] data;
        logic             full;
        logic             ovr;
        logic             nf;
        logic             fe;
        logic             pf;
    } hold_t;

    hold_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_read) begin
            r_d.full = 1'b0;
            r_d.ovr  = 1'b0;
            r_d.nf   = 1'b0;
            r_d.fe   = 1'b0;
            r_d.pf   = 1'b0;
        end
        if (done) begin
            if (r_q.full && !host_read) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data = word.field;
                r_d.full = 1'b1;
                r_d.nf   = word.noise;
                r_d.fe   = word.frame_err;
                r_d.pf   = word.parity_err;
            end
        end
        if (reject) r_d.nf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data       = r_q.data;
    assign full       = r_q.full;
    assign overrun    = r_q.ovr;
    assign noise      = r_q.nf;
    assign frame_err  = r_q.fe;
    assign parity_err = r_q.pf;

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_read && !done) |=> (!full && !overrun));

    // R8
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !host_read) |=> (overrun && full && $stable(data)));

    // R9
    rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && host_read) |=> (full && !overrun));

endmodule

// File: rtl/rxo_receiver.sv
module rxo_receiver
    import rxo_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rt_tick,
    input  logic       rx_line,
    input  logic       rx_en,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       host_read,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_full,
    output logic       rx_overrun,
    output logic       rx_noise,
    output logic       rx_frame_err,
    output logic       rx_parity_err
);

    localparam int FLD_W = rxo_pkg::FIELD_W;

    logic             line_s;
    logic             f_done;
    logic             f_reject;
    rx_word_t         f_word;
    logic [FLD_W-1:0] held;

    rxo_line_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    rxo_frame_fsm #(
        .OSR   (OSR),
        .FLD_W (FLD_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (rt_tick),
        .line        (line_s),
        .en          (rx_en),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .done        (f_done),
        .reject      (f_reject),
        .word        (f_word)
    );

    rxo_result_reg #(
        .FLD_W (FLD_W)
    ) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (f_done),
        .reject     (f_reject),
        .word       (f_word),
        .host_read  (host_read),
        .data       (held),
        .full       (rx_full),
        .overrun    (rx_overrun),
        .noise      (rx_noise),
        .frame_err  (rx_frame_err),
        .parity_err (rx_parity_err)
    );

    assign rx_data = held[7:0];
    assign rx_bit8 = held[8];

    // R2
    reject_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_reject |=> (rx_noise && $stable(rx_full)));

    // R6
    frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !rx_full && f_word.frame_err) |=> (rx_frame_err && rx_full));

endmodule

// File: tb/rxo_receiver_tb.sv
module rxo_receiver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [8:0] fld;
        bit         nf;
        bit         fe;
        bit         pe;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rt_tick = 1'b0;
    logic rx_line = 1'b1;
    logic rx_en = 1'b1;
    logic cfg_nine = 1'b0;
    logic cfg_par_en = 1'b0;
    logic cfg_par_odd = 1'b0;
    logic drv_read = 1'b0;
    logic mon_read = 1'b0;
    logic host_read;
    logic [7:0] rx_data;
    logic rx_bit8, rx_full, rx_overrun, rx_noise, rx_frame_err, rx_parity_err;

    logic [1:0] div = '0;
    bit   auto_read = 1'b1;
    int   n_tests = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    assign host_read = drv_read | mon_read;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        div     <= div + 2'd1;
        rt_tick <= (div == 2'd2);
    end

    rxo_receiver dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rt_tick       (rt_tick),
        .rx_line       (rx_line),
        .rx_en         (rx_en),
        .cfg_nine      (cfg_nine),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .host_read     (host_read),
        .rx_data       (rx_data),
        .rx_bit8       (rx_bit8),
        .rx_full       (rx_full),
        .rx_overrun    (rx_overrun),
        .rx_noise      (rx_noise),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Return at the negedge following a tick edge; optionally strobe a read on that tick edge.
    task automatic wait_tick(input bit rd);
        do @(negedge clk); while (!rt_tick);
        if (rd) drv_read = 1'b1;
        @(negedge clk);
        drv_read = 1'b0;
    endtask

    task automatic idle_ticks(input int n);
        rx_line = 1'b1;
        for (int i = 0; i < n; i++) wait_tick(1'b0);
    endtask

    task automatic host_take();
        @(negedge clk);
        drv_read = 1'b1;
        @(negedge clk);
        drv_read = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] fld, input bit stop_v,
                              input int g_bit, input int g_tick, input bit rd_at_stop);
        int nlen;
        nlen = cfg_nine ? 9 : 8;
        for (int b = 0; b <= nlen + 1; b++) begin
            logic v;
            v = (b == 0) ? 1'b0 : ((b <= nlen) ? fld[b-1] : stop_v);
            for (int t = 1; t <= 16; t++) begin
                rx_line = v ^ ((b == g_bit) && (t == g_tick));
                wait_tick(rd_at_stop && (b == nlen + 1) && (t == 10));
            end
        end
        idle_ticks(4);
    endtask

    function automatic bit par_bad(input logic [8:0] fld);
        return cfg_par_en && ((^fld) != cfg_par_odd);
    endfunction

    task automatic push(input logic [8:0] fld, input bit nf, input bit fe, input string req);
        exp_t e;
        e.fld = cfg_nine ? fld : {1'b0, fld[7:0]};
        e.nf  = nf;
        e.fe  = fe;
        e.pe  = par_bad(e.fld);
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each newly full word against the scoreboard head
    initial begin
        logic full_prev;
        full_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rx_full && !full_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected word", {7'd0, rx_bit8, rx_data}, 16'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({rx_bit8, rx_data} == e.fld, {e.req, " data"}, {7'd0, rx_bit8, rx_data}, {7'd0, e.fld});
                    chk(rx_noise == e.nf, {e.req, " noise"}, {15'd0, rx_noise}, {15'd0, e.nf});
                    chk(rx_frame_err == e.fe, {e.req, " frame"}, {15'd0, rx_frame_err}, {15'd0, e.fe});
                    chk(rx_parity_err == e.pe, {e.req, " parity"}, {15'd0, rx_parity_err}, {15'd0, e.pe});
                end
                if (auto_read) begin
                    mon_read = 1'b1;
                    @(negedge clk);
                    mon_read = 1'b0;
                end
            end
            full_prev = rx_full;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        chk(1'b0, "watchdog", 16'h0, 16'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({rx_bit8, rx_data, rx_full, rx_overrun, rx_noise, rx_frame_err, rx_parity_err} == '0,
            "R1 reset outputs", {2'd0, rx_bit8, rx_data, rx_full, rx_overrun, rx_noise, rx_frame_err, rx_parity_err}, 16'h0);
        idle_ticks(4);

        // R4: plain 8-bit characters
        push(9'h0A5, 0, 0, "R4 8b A5");  send_frame(9'h0A5, 1, -1, 0, 0);
        push(9'h03C, 0, 0, "R4 8b 3C");  send_frame(9'h03C, 1, -1, 0, 0);

        // R5: parity even good, even bad, odd good
        cfg_par_en = 1'b1;
        push(9'h035, 0, 0, "R5 even ok");  send_frame(9'h035, 1, -1, 0, 0);
        push(9'h0B5, 0, 0, "R5 even bad"); send_frame(9'h0B5, 1, -1, 0, 0);
        cfg_par_odd = 1'b1;
        push(9'h0B5, 0, 0, "R5 odd ok");   send_frame(9'h0B5, 1, -1, 0, 0);
        cfg_par_odd = 1'b0;
        cfg_par_en  = 1'b0;

        // R4: 9-bit field, ninth bit on its own port
        cfg_nine = 1'b1;
        push(9'h1C3, 0, 0, "R4 9b 1C3");  send_frame(9'h1C3, 1, -1, 0, 0);
        cfg_par_en = 1'b1;
        push(9'h1C3, 0, 0, "R5 9b par");  send_frame(9'h1C3, 1, -1, 0, 0);
        cfg_par_en = 1'b0;
        cfg_nine   = 1'b0;

        // R3: one disagreeing sample at RT9 of data bit 2 (field bit 2, value 1)
        push(9'h0A5, 1, 0, "R3 data vote"); send_frame(9'h0A5, 1, 3, 9, 0);
        // R3: disagreeing sample at RT8 of the stop bit
        push(9'h05A, 1, 0, "R3 stop vote"); send_frame(9'h05A, 1, 9, 8, 0);
        // R2: single high sample at RT5 of the start bit, start still accepted
        push(9'h011, 1, 0, "R2 start one"); send_frame(9'h011, 1, 0, 5, 0);

        // R6: stop bit low
        push(9'h0F0, 0, 1, "R6 framing"); send_frame(9'h0F0, 0, -1, 0, 0);
        idle_ticks(4);
        // R6: next character after line high again
        push(9'h00F, 0, 0, "R6 rearm");   send_frame(9'h00F, 1, -1, 0, 0);

        // R2: glitch of two low ticks is rejected, noise set, no word
        rx_line = 1'b0; wait_tick(0); wait_tick(0);
        idle_ticks(10);
        chk(rx_full == 1'b0, "R2 reject no word", {15'd0, rx_full}, 16'h0);
        chk(rx_noise == 1'b1, "R2 reject noise", {15'd0, rx_noise}, 16'h1);
        host_take();
        chk(rx_noise == 1'b0, "R7 read clears noise", {15'd0, rx_noise}, 16'h0);

        // R8: overrun keeps old word
        auto_read = 1'b0;
        push(9'h012, 0, 0, "R8 first"); send_frame(9'h012, 1, -1, 0, 0);
        send_frame(9'h0EF, 0, -1, 0, 0);
        idle_ticks(2);
        chk(rx_overrun == 1'b1, "R8 overrun set", {15'd0, rx_overrun}, 16'h1);
        chk(rx_data == 8'h12, "R8 old data kept", {8'd0, rx_data}, 16'h0012);
        chk(rx_frame_err == 1'b0, "R8 old flags kept", {15'd0, rx_frame_err}, 16'h0);
        host_take();
        chk({rx_full, rx_overrun} == 2'b00, "R7 read clears full", {14'd0, rx_full, rx_overrun}, 16'h0);

        // R9: read in the same cycle as completion
        push(9'h021, 0, 0, "R9 first"); send_frame(9'h021, 1, -1, 0, 0);
        send_frame(9'h0C4, 1, -1, 0, 1);
        chk(rx_data == 8'hC4, "R9 new word loaded", {8'd0, rx_data}, 16'h00C4);
        chk({rx_full, rx_overrun} == 2'b10, "R9 full no overrun", {14'd0, rx_full, rx_overrun}, 16'h0002);
        host_take();
        auto_read = 1'b1;

        // R10: disabled receiver ignores a character
        rx_en = 1'b0;
        send_frame(9'h077, 1, -1, 0, 0);
        chk({rx_full, rx_noise, rx_frame_err} == 3'b000, "R10 ignored", {13'd0, rx_full, rx_noise, rx_frame_err}, 16'h0);
        rx_en = 1'b1;
        idle_ticks(4);
        push(9'h099, 0, 0, "R10 reenabled"); send_frame(9'h099, 1, -1, 0, 0);

        idle_ticks(4);
        chk(exp_q.size() == 0, "R7 all words seen", 16'(exp_q.size()), 16'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule